// File: doc/BRIEF.md
# Standby Mode Control Register

An 8-bit control register that sits on the CPU's register bus of a small microcontroller and drives its power-management logic. Most of its bits are command strobes: a write with the right bit set sends the core into stop, sleep or watch mode, or starts a software reset. These bits read back fixed values. One ordinary stored bit chooses what the external pins do while the core is stopped or watching: they either keep their levels or float.

The block keeps the current low-power state in a small state machine with four states. A wake-up input brings the core back from sleep or watch. Stop is left only after the wake-up has been seen and the oscillation stabilization timer reports done. Entering watch mode is allowed only while the slow subclock is selected. A software reset pulse is timed in instruction cycles by an enable input. If the reset was issued on the subclock, the pulse is held until stabilization is done, because the core restarts on the main clock.

Top module: `standby_ctrl_reg`

## Requirements
- R1: After reset the mode output is run (code 0), the pin-float output and the software-reset output are low, and a read returns 8'h10.
- R2: A read returns 0 on bits 7, 6, 3 and 2..0, returns 1 on bit 4, and returns the stored pin-state bit on bit 5.
- R3: In run, a write with bit 7 set moves the mode to stop (code 2) at that clock edge. Stop has priority over sleep and watch in the same write.
- R4: In run, a write with bit 6 set and bit 7 clear moves the mode to sleep (code 1). Sleep has priority over watch.
- R5: In run, a write with bit 3 set and bits 7..6 clear enters watch (code 3) only when subclk_sel is 0. Otherwise it is ignored and the mode stays run.
- R6: Writing 0 to bits 7, 6 and 3 has no effect, and mode commands written outside run do not change the mode.
- R7: In sleep or watch, wake_req high at a clock edge returns the mode to run at that edge.
- R8: Stop is left for run at the first edge where stab_done is high and wake_req is high at that edge or was high at an earlier edge since stop was entered.
- R9: Bit 5 is stored on every write. pin_hiz is high exactly when that bit is 1 and the mode is stop or watch.
- R10: A write with bit 4 clear raises sw_rst from the following cycle. sw_rst stays high until the edge that sees the fourth insn_cyc_en after the write. A new such write restarts the count. Writing 1 to bit 4 has no effect.
- R11: If subclk_sel was 0 when the reset write happened, sw_rst stays high after the count ends, until an edge where stab_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| subclk_sel | input | 1 | Clock select: 0 selects the subclock |
| insn_cyc_en | input | 1 | One pulse per instruction cycle |
| wake_req | input | 1 | Wake-up request |
| stab_done | input | 1 | Oscillation stabilization finished |
| mode_o | output | 2 | Low-power state: 0 run, 1 sleep, 2 stop, 3 watch |
| pin_hiz | output | 1 | External pins float |
| sw_rst | output | 1 | Software reset source |

## Verification
The hardest situation to reach is the software reset that was issued on the subclock. For it, the four instruction-cycle pulses have to finish before stab_done arrives, so the reset is held after its count. Directed sequences hold stab_done low through the count, raise it later, and also issue a second reset while the count is running. A second hard case is leaving stop with the wake-up and the stabilization flag arriving at different edges. Long random runs keep stab_done sparse so that the pending wake is exercised often, and a bench model follows every cycle.

// File: rtl/stbc_pkg.sv
package stbc_pkg;
   typedef enum logic [1:0] {
      MD_RUN   = 2'd0,
      MD_SLEEP = 2'd1,
      MD_STOP  = 2'd2,
      MD_WATCH = 2'd3
   } stbc_mode_e;

   localparam int unsigned REG_W      = 8;
   localparam int unsigned BIT_STOP   = 7;
   localparam int unsigned BIT_SLEEP  = 6;
   localparam int unsigned BIT_PINFLT = 5;
   localparam int unsigned BIT_SWRST  = 4;
   localparam int unsigned BIT_WATCH  = 3;
endpackage

// File: rtl/stbc_mode_fsm.sv
module stbc_mode_fsm
   import stbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_stop,
   input  logic       cmd_sleep,
   input  logic       cmd_watch,
   input  logic       subclk_sel,
   input  logic       wake_req,
   input  logic       stab_done,
   output stbc_mode_e mode_q
);
   stbc_mode_e mode_d;
   logic       pend_q, pend_d;

   always_comb begin
      mode_d = mode_q;
      pend_d = pend_q;
      unique case (mode_q)
         MD_RUN: begin
            pend_d = 1'b0;
            if (cmd_stop)                       mode_d = MD_STOP;
            else if (cmd_sleep)                 mode_d = MD_SLEEP;
            else if (cmd_watch && !subclk_sel)  mode_d = MD_WATCH;
         end
         MD_SLEEP, MD_WATCH: begin
            if (wake_req) mode_d = MD_RUN;
         end
         MD_STOP: begin
            if ((wake_req || pend_q) && stab_done) begin
               mode_d = MD_RUN;
               pend_d = 1'b0;
            end else if (wake_req) begin
               pend_d = 1'b1;
            end
         end
         default: mode_d = MD_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_RUN;
         pend_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         pend_q <= pend_d;
      end
   end

   // R8: stop is held while stabilization is not done
   assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_STOP && !stab_done) |=> (mode_q == MD_STOP));

   // R7: wake from sleep or watch returns to run
   assert_wake_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MD_SLEEP || mode_q == MD_WATCH) && wake_req) |=> (mode_q == MD_RUN));

   // R5: watch cannot be entered while the main clock is selected
   assert_watch_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RUN && subclk_sel) |=> (mode_q != MD_WATCH));

   // R3: stop command from run always lands in stop
   assert_stop_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RUN && cmd_stop) |=> (mode_q == MD_STOP));

   // R6: without commands, run is kept
   assert_run_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RUN && !cmd_stop && !cmd_sleep && !cmd_watch) |=> (mode_q == MD_RUN));
endmodule

// File: rtl/stbc_swrst_timer.sv
module stbc_swrst_timer #(
   parameter int unsigned RST_CYCLES = 4,
   localparam int unsigned CNT_W = $clog2(RST_CYCLES),
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic from_subclk,
   input  logic tick,
   input  logic stab_done,
   output logic rst_out
);
   generate
      if (RST_CYCLES < 2) begin : g_bad_cycles
         $error("RST_CYCLES must be at least 2");
      end
   endgenerate

   logic             act_q, hold_en_q, hold_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         hold_en_q <= 1'b0;
         hold_q    <= 1'b0;
         cnt_q     <= '0;
      end else if (start) begin
         act_q     <= 1'b1;
         hold_en_q <= from_subclk;
         hold_q    <= 1'b0;
         cnt_q     <= '0;
      end else if (act_q) begin
         if (tick) begin
            if (cnt_q == CNT_LAST) begin
               act_q  <= 1'b0;
               hold_q <= hold_en_q;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else if (hold_q && stab_done) begin
         hold_q <= 1'b0;
      end
   end

   assign rst_out = act_q | hold_q;

   // R10: the pulse only begins after a start request
   assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out) |-> $past(start));

   // R10: counter stays inside its range
   assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

   // R11: the hold phase ends only on stabilization done or a restart
   assert_hold_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !act_q && !stab_done && !start) |=> hold_q);
endmodule

// File: rtl/standby_ctrl_reg.sv
module standby_ctrl_reg
   import stbc_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 4,
   parameter bit          HIZ_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             subclk_sel,
   input  logic             insn_cyc_en,
   input  logic             wake_req,
   input  logic             stab_done,
   output logic [1:0]       mode_o,
   output logic             pin_hiz,
   output logic             sw_rst
);
   stbc_mode_e mode_q;
   logic       pinflt_q;
   logic       cmd_stop, cmd_sleep, cmd_watch, cmd_rst;

   assign cmd_stop  = wr_en &  wr_data[BIT_STOP];
   assign cmd_sleep = wr_en &  wr_data[BIT_SLEEP];
   assign cmd_watch = wr_en &  wr_data[BIT_WATCH];
   assign cmd_rst   = wr_en & ~wr_data[BIT_SWRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pinflt_q <= 1'b0;
      else if (wr_en) pinflt_q <= wr_data[BIT_PINFLT];
   end

   stbc_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_stop   (cmd_stop),
      .cmd_sleep  (cmd_sleep),
      .cmd_watch  (cmd_watch),
      .subclk_sel (subclk_sel),
      .wake_req   (wake_req),
      .stab_done  (stab_done),
      .mode_q     (mode_q)
   );

   stbc_swrst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (cmd_rst),
      .from_subclk (~subclk_sel),
      .tick        (insn_cyc_en),
      .stab_done   (stab_done),
      .rst_out     (sw_rst)
   );

   logic lowpwr_float;
   assign lowpwr_float = pinflt_q & ((mode_q == MD_STOP) | (mode_q == MD_WATCH));

   generate
      if (HIZ_REG) begin : g_hiz_reg
         logic hiz_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hiz_q <= 1'b0;
            else        hiz_q <= lowpwr_float;
         end
         assign pin_hiz = hiz_q;
      end else begin : g_hiz_comb
         assign pin_hiz = lowpwr_float;
      end
   endgenerate

   always_comb begin
      rd_data             = '0;
      rd_data[BIT_PINFLT] = pinflt_q;
      rd_data[BIT_SWRST]  = 1'b1;
   end

   assign mode_o = mode_q;

   // R9: pins never float while running or sleeping
   assert_hiz_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MD_RUN || mode_o == MD_SLEEP) |=> (HIZ_REG ? 1'b1 : !pin_hiz) || mode_o == MD_STOP || mode_o == MD_WATCH);

   // R2: command bits always read back their fixed values
   assert_rd_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[BIT_STOP] == 1'b0 && rd_data[BIT_SWRST] == 1'b1 && rd_data[BIT_WATCH] == 1'b0));

   // R9: pin-state bit follows the last write
   assert_pin_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[BIT_PINFLT] == $past(wr_data[BIT_PINFLT])));
endmodule

// File: tb/sim_standby_ctrl_reg.sv
module sim_standby_ctrl_reg;
   localparam int CLK_PERIOD = 10;
   localparam int RSTC = 4;
   localparam int WATCHDOG_CYC = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       subclk_sel = 1'b1;
   logic       insn_cyc_en = 1'b0;
   logic       wake_req = 1'b0;
   logic       stab_done = 1'b0;
   logic [1:0] mode_o;
   logic       pin_hiz, sw_rst;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // bench model state
   int m_mode = 0;
   bit m_pend = 0, m_pin = 0, m_act = 0, m_hold_en = 0, m_hold = 0;
   int m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   standby_ctrl_reg u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .subclk_sel(subclk_sel), .insn_cyc_en(insn_cyc_en), .wake_req(wake_req),
      .stab_done(stab_done), .mode_o(mode_o), .pin_hiz(pin_hiz), .sw_rst(sw_rst)
   );

   function automatic logic [7:0] exp_rd(bit pin);
      return {2'b00, pin, 1'b1, 4'b0000};
   endfunction

   function automatic bit exp_hiz(int md, bit pin);
      return pin && (md == 2 || md == 3);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // advance the model by one clock edge using the inputs currently applied
   task automatic model_edge();
      int nm = m_mode;
      bit np = m_pend;
      case (m_mode)
         0: begin
            np = 0;
            if (wr_en && wr_data[7])                     nm = 2;
            else if (wr_en && wr_data[6])                nm = 1;
            else if (wr_en && wr_data[3] && !subclk_sel) nm = 3;
         end
         1, 3: if (wake_req) nm = 0;
         default: begin
            if ((wake_req || m_pend) && stab_done) begin nm = 0; np = 0; end
            else if (wake_req) np = 1;
         end
      endcase
      m_mode = nm;
      m_pend = np;
      if (wr_en) m_pin = wr_data[5];
      if (wr_en && !wr_data[4]) begin
         m_act = 1; m_hold_en = !subclk_sel; m_hold = 0; m_cnt = 0;
      end else if (m_act) begin
         if (insn_cyc_en) begin
            if (m_cnt == RSTC - 1) begin m_act = 0; m_hold = m_hold_en; m_cnt = 0; end
            else m_cnt++;
         end
      end else if (m_hold && stab_done) m_hold = 0;
   endtask

   task automatic compare_all(input string tag);
      chk(mode_o == m_mode[1:0], {tag, " mode R3 R4 R5 R7 R8"}, mode_o, m_mode);
      chk(pin_hiz == exp_hiz(m_mode, m_pin), {tag, " pin_hiz R9"}, pin_hiz, exp_hiz(m_mode, m_pin));
      chk(sw_rst == (m_act || m_hold), {tag, " sw_rst R10 R11"}, sw_rst, m_act || m_hold);
      chk(rd_data == exp_rd(m_pin), {tag, " rd_data R2"}, rd_data, exp_rd(m_pin));
   endtask

   // one cycle: inputs applied now (just after an edge), then edge, then compare
   task automatic cyc(input bit w, input logic [7:0] d, input bit wk, input bit dn,
                      input bit sub, input bit en, input string tag);
      wr_en = w; wr_data = d; wake_req = wk; stab_done = dn; subclk_sel = sub; insn_cyc_en = en;
      @(posedge clk);
      model_edge();
      #1;
      compare_all(tag);
   endtask

   task automatic idle(input int n, input bit sub, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 8'h10, 0, 0, sub, 0, tag);
   endtask

   initial begin : watchdog
      for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      chk(mode_o == 2'd0, "R1 mode after reset", mode_o, 0);
      chk(pin_hiz == 1'b0, "R1 pin_hiz after reset", pin_hiz, 0);
      chk(sw_rst == 1'b0, "R1 sw_rst after reset", sw_rst, 0);
      chk(rd_data == 8'h10, "R1 rd_data after reset", rd_data, 8'h10);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R6 zero writes to command bits leave run
      cyc(1, 8'h10, 0, 0, 0, 0, "R6 zero write");
      chk(mode_o == 2'd0, "R6 mode stays run", mode_o, 0);

      // R3 stop beats sleep and watch; R9 float in stop
      cyc(1, 8'hF8, 0, 0, 0, 0, "R3 stop prio");
      chk(mode_o == 2'd2, "R3 stop entered", mode_o, 2);
      chk(pin_hiz == 1'b1, "R9 float in stop", pin_hiz, 1);
      chk(rd_data == 8'h30, "R2 rd after pin set", rd_data, 8'h30);
      // R6 command in stop ignored
      cyc(1, 8'h70, 0, 0, 0, 0, "R6 cmd in stop");
      chk(mode_o == 2'd2, "R6 sleep cmd in stop ignored", mode_o, 2);
      // R8 wake without done, later done
      cyc(0, 8'h10, 1, 0, 0, 0, "R8 wake no done");
      chk(mode_o == 2'd2, "R8 stop held without done", mode_o, 2);
      idle(3, 0, "R8 pending");
      cyc(0, 8'h10, 0, 1, 0, 0, "R8 done");
      chk(mode_o == 2'd0, "R8 stop left on done", mode_o, 0);
      // R8 done without wake does not leave
      cyc(1, 8'h90, 0, 0, 0, 0, "R8 reenter stop");
      cyc(0, 8'h10, 0, 1, 0, 0, "R8 done only");
      chk(mode_o == 2'd2, "R8 done alone ignored", mode_o, 2);
      cyc(0, 8'h10, 1, 1, 0, 0, "R8 wake+done");
      chk(mode_o == 2'd0, "R8 same edge exit", mode_o, 0);

      // R4 sleep beats watch; R9 no float in sleep
      cyc(1, 8'h78, 0, 0, 0, 0, "R4 sleep prio");
      chk(mode_o == 2'd1, "R4 sleep entered", mode_o, 1);
      chk(pin_hiz == 1'b0, "R9 no float in sleep", pin_hiz, 0);
      cyc(0, 8'h10, 1, 0, 0, 0, "R7 wake sleep");
      chk(mode_o == 2'd0, "R7 sleep wake", mode_o, 0);

      // R5 watch blocked on main clock, allowed on subclock
      cyc(1, 8'h38, 0, 0, 1, 0, "R5 watch blocked");
      chk(mode_o == 2'd0, "R5 watch ignored on main clock", mode_o, 0);
      cyc(1, 8'h38, 0, 0, 0, 0, "R5 watch ok");
      chk(mode_o == 2'd3, "R5 watch entered", mode_o, 3);
      chk(pin_hiz == 1'b1, "R9 float in watch", pin_hiz, 1);
      cyc(0, 8'h10, 1, 0, 0, 0, "R7 wake watch");
      chk(mode_o == 2'd0, "R7 watch wake", mode_o, 0);

      // R10 reset on main clock: four ticks
      cyc(1, 8'h00, 0, 0, 1, 1, "R10 start");
      chk(sw_rst == 1'b1, "R10 rst raised", sw_rst, 1);
      cyc(0, 8'h10, 0, 0, 1, 1, "R10 t1");
      cyc(0, 8'h10, 0, 0, 1, 0, "R10 gap");
      cyc(0, 8'h10, 0, 0, 1, 1, "R10 t2");
      cyc(0, 8'h10, 0, 0, 1, 1, "R10 t3");
      chk(sw_rst == 1'b1, "R10 rst still high after 3 ticks", sw_rst, 1);
      cyc(0, 8'h10, 0, 0, 1, 1, "R10 t4");
      chk(sw_rst == 1'b0, "R10 rst ends after 4 ticks", sw_rst, 0);
      // R10 writing 1 to bit 4 has no effect
      cyc(1, 8'h10, 0, 0, 1, 1, "R10 write one");
      chk(sw_rst == 1'b0, "R10 write one no reset", sw_rst, 0);

      // R11 reset on subclock held until stab_done; R10 retrigger
      cyc(1, 8'h00, 0, 0, 0, 1, "R11 start");
      cyc(0, 8'h00, 0, 0, 0, 1, "R11 t1");
      cyc(0, 8'h00, 0, 0, 0, 1, "R11 t2");
      cyc(1, 8'h00, 0, 0, 0, 0, "R10 retrigger");
      for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 0, 1, 1, "R11 ticks");
      chk(sw_rst == 1'b1, "R11 held after count", sw_rst, 1);
      idle(3, 1, "R11 hold");
      cyc(0, 8'h10, 0, 1, 1, 0, "R11 done");
      chk(sw_rst == 1'b0, "R11 released on done", sw_rst, 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         bit w, wk, dn, en, sub;
         logic [7:0] d;
         w   = ($urandom % 4) == 0;
         d   = 8'($urandom);
         if (($urandom % 3) != 0) d[4] = 1'b1;
         wk  = ($urandom % 8) == 0;
         dn  = ($urandom % 6) == 0;
         en  = ($urandom % 2) == 0;
         sub = ($urandom % 2) == 0;
         cyc(w, d, wk, dn, sub, en, "random");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule